// File: doc/BRIEF.md
# Power-Good Strap Latch Controller

This block takes two frequency-select straps that share their pins with reference-clock outputs. It captures them exactly once, when an active-low power-good strobe is first seen low.

The strobe first passes through a synchronizer on the reference clock. On the edge that first sees the synchronized low, the two strap levels are latched into a two-bit code. From that edge on the code stays fixed until the next power-on reset. The code goes to divider-control logic downstream, together with a valid flag.

After capture, both shared pins turn from inputs into outputs that carry the reference clock. If the latched code equals a test encoding, the block enters test-clock mode. In this mode, pin A stays an input, and its level chooses, without any clock, whether pin B is tri-stated or drives the reference divided by N. Test mode is left only through power-on reset.

Top module: `strap_latch_ctrl`

## Requirements
- R1: While `por_n` is low, `code_valid` and `test_mode` are 0, `code` is 2'b00 and both pad output enables are 0.
- R2: When `pwrgd_n` is low before a rising edge of `clk_ref`, `code_valid` goes high on the third rising edge counted from that edge, with the default two-stage synchronizer. On that same edge, `code` takes {`strap_b_in`, `strap_a_in`}: bit 0 is strap A and bit 1 is strap B.
- R3: Until `code_valid` is high, `pad_a_oe` and `pad_b_oe` are 0, whatever the strap levels are.
- R4: Once `code_valid` is high, later changes on `pwrgd_n`, `strap_a_in` and `strap_b_in` leave `code`, `code_valid` and `test_mode` unchanged.
- R5: After capture with a code other than the test encoding, both output enables are 1 and both pad outputs follow `clk_ref`.
- R6: `test_mode` goes high on the capture edge if and only if the captured code equals `TEST_CODE` (default 2'b11).
- R7: In test mode, `pad_a_oe` is 0. `pad_b_oe` follows `strap_a_in` combinationally: 1 drives pin B and 0 tri-states it. A change in `strap_a_in` between clock edges takes effect with no clock edge.
- R8: In test mode, `pad_b_out` is `clk_ref` divided by `DIV_N` (default 4), with a 50 % duty cycle.
- R9: In test mode, a change on `strap_b_in` affects none of the outputs.
- R10: Test mode and the latched code survive `pwrgd_n` returning high. Only a low on `por_n` clears them, and that low also re-arms a new capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| pwrgd_n | input | 1 | Power-good strobe, active low |
| strap_a_in | input | 1 | Level seen on shared pin A |
| strap_b_in | input | 1 | Level seen on shared pin B |
| code | output | 2 | Latched frequency code {B, A} |
| code_valid | output | 1 | Code has been captured |
| test_mode | output | 1 | Test-clock mode active |
| pad_a_oe | output | 1 | Output enable for pin A |
| pad_a_out | output | 1 | Data driven on pin A |
| pad_b_oe | output | 1 | Output enable for pin B |
| pad_b_out | output | 1 | Data driven on pin B |

## Verification
Two events can fall in the same edge: the capture, and a strap or strobe change that would alter the code if capture were not one-shot. The bench provokes this by flipping both straps and pulsing the strobe again right after `code_valid` rises, then judges `code` against the value latched at the capture edge. In test mode, the asynchronous enable path on pin B and the clocked divider act together. The bench toggles `strap_a_in` between edges and checks `pad_b_oe` one time step later, then counts the divided edges with strap A held high.

// File: rtl/strap_pkg.sv
package strap_pkg;
    localparam int CODE_W = 2;

    typedef struct packed {
        logic              valid;
        logic              test;
        logic [CODE_W-1:0] code;
    } cap_state_t;
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_n,
    output logic sync_n
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = raw_n;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], raw_n};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/strap_capture.sv
module strap_capture
    import strap_pkg::*;
#(
    parameter logic [CODE_W-1:0] TEST_CODE = 2'b11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pg_sync_n,
    input  logic [CODE_W-1:0] straps,
    output logic [CODE_W-1:0] code,
    output logic              valid,
    output logic              test
);
    cap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.valid && !pg_sync_n) begin
            st_d.valid = 1'b1;
            st_d.code  = straps;
            st_d.test  = (straps == TEST_CODE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code  = st_q.code;
    assign valid = st_q.valid;
    assign test  = st_q.test;

    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> valid && $stable(code) && $stable(test)); // R4
    AST_CAPTURE_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> $past(!pg_sync_n)); // R2
    AST_TEST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        test |-> valid && code == TEST_CODE); // R6
endmodule

// File: rtl/ref_divider.sv
module ref_divider #(
    parameter int DIV_N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic div_clk
);
    localparam int HALF = (DIV_N / 2 < 1) ? 1 : DIV_N / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt_d, cnt_q;
    logic          div_d, div_q;

    always_comb begin
        cnt_d = cnt_q;
        div_d = div_q;
        if (!en) begin
            cnt_d = '0;
            div_d = 1'b0;
        end else if (cnt_q == CW'(HALF - 1)) begin
            cnt_d = '0;
            div_d = ~div_q;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            div_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            div_q <= div_d;
        end
    end

    assign div_clk = div_q;

    AST_DIV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !div_clk); // R8
endmodule

// File: rtl/pad_ctrl.sv
module pad_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_clk,
    input  logic valid,
    input  logic test,
    input  logic sel_a,
    input  logic div_clk,
    output logic a_oe,
    output logic a_out,
    output logic b_oe,
    output logic b_out
);
    always_comb begin
        a_oe  = 1'b0;
        a_out = 1'b0;
        b_oe  = 1'b0;
        b_out = 1'b0;
        if (test) begin
            b_oe  = sel_a;
            b_out = div_clk;
        end else if (valid) begin
            a_oe  = 1'b1;
            a_out = ref_clk;
            b_oe  = 1'b1;
            b_out = ref_clk;
        end
    end

    AST_PINS_INPUT_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> !a_oe && !b_oe); // R3
    AST_TEST_A_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        test |-> !a_oe && (b_oe == sel_a)); // R7
endmodule

// File: rtl/strap_latch_ctrl.sv
module strap_latch_ctrl
    import strap_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter int                DIV_N       = 4,
    parameter logic [CODE_W-1:0] TEST_CODE   = 2'b11
) (
    input  logic              clk_ref,
    input  logic              por_n,
    input  logic              pwrgd_n,
    input  logic              strap_a_in,
    input  logic              strap_b_in,
    output logic [CODE_W-1:0] code,
    output logic              code_valid,
    output logic              test_mode,
    output logic              pad_a_oe,
    output logic              pad_a_out,
    output logic              pad_b_oe,
    output logic              pad_b_out
);
    logic pg_sync_n;
    logic div_clk;

    strap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk_ref),
        .rst_n (por_n),
        .raw_n (pwrgd_n),
        .sync_n(pg_sync_n)
    );

    strap_capture #(.TEST_CODE(TEST_CODE)) u_cap (
        .clk      (clk_ref),
        .rst_n    (por_n),
        .pg_sync_n(pg_sync_n),
        .straps   ({strap_b_in, strap_a_in}),
        .code     (code),
        .valid    (code_valid),
        .test     (test_mode)
    );

    ref_divider #(.DIV_N(DIV_N)) u_div (
        .clk    (clk_ref),
        .rst_n  (por_n),
        .en     (test_mode),
        .div_clk(div_clk)
    );

    pad_ctrl u_pad (
        .clk    (clk_ref),
        .rst_n  (por_n),
        .ref_clk(clk_ref),
        .valid  (code_valid),
        .test   (test_mode),
        .sel_a  (strap_a_in),
        .div_clk(div_clk),
        .a_oe   (pad_a_oe),
        .a_out  (pad_a_out),
        .b_oe   (pad_b_oe),
        .b_out  (pad_b_out)
    );
endmodule

// File: tb/tb_strap_latch_ctrl.sv
module tb_strap_latch_ctrl;
    localparam int CLK_PERIOD = 10;

    logic clk_ref = 1'b0;
    logic por_n = 1'b0, pwrgd_n = 1'b1, strap_a_in = 1'b0, strap_b_in = 1'b0;
    logic [1:0] code;
    logic code_valid, test_mode, pad_a_oe, pad_a_out, pad_b_oe, pad_b_out;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

    strap_latch_ctrl dut (.*);

    // {strap_a, strap_b, expected code[1:0], expected test}
    localparam logic [4:0] VEC [4] = '{
        {1'b0, 1'b0, 2'b00, 1'b0},
        {1'b1, 1'b0, 2'b01, 1'b0},
        {1'b0, 1'b1, 2'b10, 1'b0},
        {1'b1, 1'b1, 2'b11, 1'b1}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic por();
        @(negedge clk_ref);
        por_n = 1'b0;
        pwrgd_n = 1'b1;
        @(negedge clk_ref);
        chk(code_valid == 0 && test_mode == 0 && code == 0, "R1 state in reset",
            {code_valid, test_mode, code}, 0);
        chk(pad_a_oe == 0 && pad_b_oe == 0, "R1 oe in reset", {pad_a_oe, pad_b_oe}, 0);
        por_n = 1'b1;
    endtask

    task automatic capture();
        pwrgd_n = 1'b0;
        repeat (2) @(negedge clk_ref);
        chk(code_valid == 0, "R2 not valid after two edges", code_valid, 0);
        @(negedge clk_ref);
        chk(code_valid == 1, "R2 valid on third edge", code_valid, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            por();
            strap_a_in = VEC[i][4];
            strap_b_in = VEC[i][3];
            repeat (3) @(negedge clk_ref);
            chk(pad_a_oe == 0 && pad_b_oe == 0, "R3 pins input before capture",
                {pad_a_oe, pad_b_oe}, 0);
            strap_a_in = ~strap_a_in;
            @(negedge clk_ref);
            chk(pad_a_oe == 0 && pad_b_oe == 0, "R3 strap change pre capture",
                {pad_a_oe, pad_b_oe}, 0);
            strap_a_in = VEC[i][4];
            capture();
            chk(code == VEC[i][2:1], "R2 captured code", code, VEC[i][2:1]);
            chk(test_mode == VEC[i][0], "R6 test flag", test_mode, VEC[i][0]);
            // same-edge disturbance right after capture
            strap_a_in = ~strap_a_in;
            strap_b_in = ~strap_b_in;
            pwrgd_n = 1'b1;
            repeat (3) @(negedge clk_ref);
            pwrgd_n = 1'b0;
            repeat (4) @(negedge clk_ref);
            chk(code == VEC[i][2:1] && code_valid, "R4 code held", code, VEC[i][2:1]);
            chk(test_mode == VEC[i][0], "R4 test held", test_mode, VEC[i][0]);
            if (!VEC[i][0]) begin
                chk(pad_a_oe && pad_b_oe, "R5 both pins driven", {pad_a_oe, pad_b_oe}, 3);
                chk(pad_a_out == 0 && pad_b_out == 0, "R5 outputs low with clock low",
                    {pad_a_out, pad_b_out}, 0);
                @(posedge clk_ref); #1;
                chk(pad_a_out == 1 && pad_b_out == 1, "R5 outputs high with clock high",
                    {pad_a_out, pad_b_out}, 3);
            end else begin
                @(posedge clk_ref); #2;
                strap_a_in = 1'b1; #1;
                chk(!pad_a_oe && pad_b_oe, "R7 pin B driven by strap A high",
                    {pad_a_oe, pad_b_oe}, 1);
                strap_a_in = 1'b0; #1;
                chk(!pad_a_oe && !pad_b_oe, "R7 pin B tri-stated by strap A low",
                    {pad_a_oe, pad_b_oe}, 0);
            end
        end

        // R8/R9/R10: test mode in depth
        por();
        strap_a_in = 1'b1; strap_b_in = 1'b1;
        capture();
        chk(test_mode == 1, "R6 test entered", test_mode, 1);
        begin
            int rises = 0;
            logic prev;
            @(negedge clk_ref);
            prev = pad_b_out;
            for (int k = 0; k < 32; k++) begin
                @(negedge clk_ref);
                if (pad_b_out && !prev) rises++;
                prev = pad_b_out;
            end
            chk(rises >= 7 && rises <= 9, "R8 divided reference edges", rises, 8);
        end
        begin
            int highs = 0;
            for (int k = 0; k < 16; k++) begin
                @(negedge clk_ref);
                if (pad_b_out) highs++;
            end
            chk(highs == 8, "R8 divided duty", highs, 8);
        end
        strap_b_in = 1'b0;
        repeat (3) @(negedge clk_ref);
        chk(test_mode == 1 && code == 2'b11 && pad_b_oe == 1, "R9 strap B ignored in test",
            {test_mode, code, pad_b_oe}, 15);
        pwrgd_n = 1'b1;
        repeat (10) @(negedge clk_ref);
        chk(test_mode == 1 && code_valid == 1, "R10 strobe high keeps test",
            {test_mode, code_valid}, 3);
        por();
        chk(test_mode == 0, "R10 reset leaves test", test_mode, 0);
        strap_a_in = 1'b0; strap_b_in = 1'b1;
        capture();
        chk(code == 2'b10 && test_mode == 0, "R10 re-armed capture", {code, test_mode}, 4);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule